// File: doc/BRIEF.md
# Grayscale LCD Refresh Controller

This block keeps a dot-matrix LCD panel refreshed from a frame buffer that sits in shared system memory. For every visible line it fetches the line's bytes through a request/grant port into a small line FIFO. It unpacks each byte into 1-, 2- or 4-bit pixel codes and looks each code up in a palette of 5-bit intensity levels. A frame-rate-control phase that advances once per frame turns each level into an on/off dot. The dots are packed into words for a 1-, 4- or 8-lane panel data bus.

The visible window is programmable in width and height. A separate start address and a line stride let the window sit anywhere inside a larger virtual screen, so software pans or scrolls by rewriting those two values. The block produces a data strobe, a line pulse, a first-line marker and a polarity-alternation signal for the panel. It also gives the processor one interrupt pulse per frame when vertical blanking begins. Memory reads are issued only while a line is being drawn, and each waits for a grant, so the processor keeps the bus for the rest of the time.

Top module: `lcd_gray_refresh`

## Requirements
- R1: While `rst_n` is low, `mem_req`, `lcd_shift`, `lcd_line`, `lcd_frame`, `lcd_alt`, `buf_irq` and `lcd_data` are all zero. After release, a blanking interval of `VBL_CYCLES` cycles passes before the first line is drawn.
- R2: `cfg_mode` 0 selects 1 bit per pixel, 1 selects 2 bits and 2 selects 4 bits. Pixels are packed most-significant-first inside each byte, and the leftmost pixel of a line starts at the top bit of the line's first byte.
- R3: Pixel code n selects palette entry n, which is `cfg_palette[5n+4:5n]`. In frame f, counted from 0 after reset, the dot is on (1) exactly when the entry is greater than f mod 32.
- R4: `cfg_bus` 0 drives lane 0 only, 1 drives lanes 3:0 and 2 drives lanes 7:0. The first dot of each word sits on the highest used lane. The last word of a line may be short, and then its lower lanes are 0. Unused lanes are always 0, and each word is marked by a one-cycle `lcd_shift`.
- R5: Each line carries exactly `cfg_width` dots, in order. It is followed by a one-cycle `lcd_line` pulse that never coincides with `lcd_shift`. Each frame has exactly `cfg_height` lines.
- R6: Line y of a frame is read from `ceil(width*bpp/8)` consecutive bytes starting at `cfg_base + y*cfg_stride`, with addresses taken modulo 2^ADDR_W.
- R7: `mem_req` is raised only while a line is active and the line FIFO has room. Once raised, it holds with a stable `mem_addr` until `mem_gnt`, and no request is made during vertical blanking.
- R8: `buf_irq` is a one-cycle pulse that comes with the line pulse of the last line of each frame and marks the start of vertical blanking. `lcd_alt` toggles on the same edge.
- R9: `lcd_frame` is high only together with the line pulse of the first line of each frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | Pixel depth: 0 = 1 bpp, 1 = 2 bpp, 2 = 4 bpp |
| cfg_bus | input | 2 | Panel bus lanes: 0 = 1, 1 = 4, 2 = 8 |
| cfg_width | input | DIM_W | Visible pixels per line (1..100) |
| cfg_height | input | DIM_W | Visible lines per frame (1..100) |
| cfg_base | input | ADDR_W | Byte address of the window's top-left pixel |
| cfg_stride | input | STRIDE_W | Bytes between successive virtual-screen lines |
| cfg_palette | input | 80 | Sixteen 5-bit intensity levels, entry n at bits 5n+4:5n |
| mem_req | output | 1 | Read request |
| mem_addr | output | ADDR_W | Read byte address |
| mem_gnt | input | 1 | Grant; data is taken in this cycle |
| mem_rdata | input | 8 | Read data, valid with the grant |
| lcd_data | output | 8 | Panel data word |
| lcd_shift | output | 1 | One-cycle strobe per data word |
| lcd_line | output | 1 | One-cycle pulse at the end of each line |
| lcd_frame | output | 1 | Marks the line pulse of the first line |
| lcd_alt | output | 1 | Polarity alternation, toggles every frame |
| buf_irq | output | 1 | One-cycle interrupt at the start of vertical blanking |

## Verification
The assertions assume that `mem_rdata` is valid in every cycle where `mem_gnt` meets `mem_req`. They also assume that the configuration inputs stay still while the block runs and that width and height are nonzero and within range. The bench changes configuration only while reset is held. It keeps every window between 1 and 100 pixels on each side. It feeds data combinationally from its memory image, so the data always matches the address in the grant cycle. Grants are given either every cycle or in a random pattern. This exercises the held-request rule without breaking any input assumption.

// File: rtl/lgr_pkg.sv
package lgr_pkg;
  localparam int PAL_W = 5;
  localparam int PAL_ENTRIES = 16;

  typedef enum logic [1:0] {ST_VBL, ST_LINE, ST_HBL} seq_st_e;

  function automatic logic [2:0] pix_bits(input logic [1:0] m);
    case (m)
      2'd0:    return 3'd1;
      2'd1:    return 3'd2;
      default: return 3'd4;
    endcase
  endfunction

  function automatic logic [2:0] sub_last(input logic [1:0] m);
    case (m)
      2'd0:    return 3'd7;
      2'd1:    return 3'd3;
      default: return 3'd1;
    endcase
  endfunction

  function automatic logic [3:0] bus_lanes(input logic [1:0] b);
    case (b)
      2'd0:    return 4'd1;
      2'd1:    return 4'd4;
      default: return 4'd8;
    endcase
  endfunction

  function automatic logic [3:0] pix_code(input logic [7:0] bval, input logic [1:0] m,
                                          input logic [2:0] sub);
    logic [7:0] sh;
    case (m)
      2'd0: begin
        sh = bval << sub;
        return {3'b000, sh[7]};
      end
      2'd1: begin
        sh = bval << {sub[1:0], 1'b0};
        return {2'b00, sh[7:6]};
      end
      default: begin
        sh = bval << {sub[0], 2'b00};
        return sh[7:4];
      end
    endcase
  endfunction

  function automatic int unsigned line_bytes(input int unsigned w, input int unsigned bpp);
    return (w * bpp + 7) / 8;
  endfunction

  function automatic logic frc_on(input logic [PAL_W-1:0] lvl, input logic [PAL_W-1:0] phase);
    return lvl > phase;
  endfunction
endpackage

// File: rtl/lgr_seq.sv
module lgr_seq
  import lgr_pkg::*;
#(
  parameter int DIM_W = 7,
  parameter int ADDR_W = 16,
  parameter int STRIDE_W = 8,
  parameter int VBL_CYCLES = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [DIM_W-1:0]    cfg_height,
  input  logic [ADDR_W-1:0]   cfg_base,
  input  logic [STRIDE_W-1:0] cfg_stride,
  input  logic                line_done,
  output logic                line_active,
  output logic [ADDR_W-1:0]   line_base,
  output logic [PAL_W-1:0]    frc_phase,
  output logic                vbl_enter,
  output logic                lcd_line,
  output logic                lcd_frame,
  output logic                lcd_alt,
  output logic                buf_irq
);
  localparam int VC_W = $clog2(VBL_CYCLES + 1);

  seq_st_e          st;
  logic [VC_W-1:0]  vcnt;
  logic [DIM_W-1:0] y;
  logic             last_line;

  assign line_active = (st == ST_LINE);
  assign last_line   = (y == DIM_W'(cfg_height - 1'b1));
  assign vbl_enter   = (st == ST_HBL) && last_line;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_VBL;
      vcnt      <= '0;
      y         <= '0;
      line_base <= '0;
      frc_phase <= '0;
      lcd_alt   <= 1'b0;
      lcd_line  <= 1'b0;
      lcd_frame <= 1'b0;
      buf_irq   <= 1'b0;
    end else begin
      lcd_line  <= 1'b0;
      lcd_frame <= 1'b0;
      buf_irq   <= 1'b0;
      case (st)
        ST_VBL: begin
          if (vcnt == VC_W'(VBL_CYCLES - 1)) begin
            vcnt      <= '0;
            y         <= '0;
            line_base <= cfg_base;
            st        <= ST_LINE;
          end else begin
            vcnt <= vcnt + 1'b1;
          end
        end
        ST_LINE: if (line_done) st <= ST_HBL;
        default: begin
          lcd_line  <= 1'b1;
          lcd_frame <= (y == '0);
          if (last_line) begin
            st        <= ST_VBL;
            buf_irq   <= 1'b1;
            lcd_alt   <= ~lcd_alt;
            frc_phase <= frc_phase + 1'b1;
          end else begin
            y         <= y + 1'b1;
            line_base <= line_base + {{(ADDR_W-STRIDE_W){1'b0}}, cfg_stride};
            st        <= ST_LINE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/lgr_fetch.sv
module lgr_fetch #(
  parameter int ADDR_W = 16,
  parameter int NB_W = 8,
  parameter int DEPTH = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_active,
  input  logic [ADDR_W-1:0] line_base,
  input  logic [NB_W-1:0]   nbytes,
  input  logic              mem_gnt,
  input  logic [7:0]        mem_rdata,
  input  logic              pop,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        head,
  output logic              fifo_empty,
  output logic [$clog2(DEPTH+1)-1:0] fifo_cnt
);
  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [7:0]      q [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [NB_W-1:0]  fb;
  logic             push, do_pop;

  assign mem_req    = line_active && (fb < nbytes) && (fifo_cnt < CNT_W'(DEPTH));
  assign mem_addr   = line_base + ADDR_W'(fb);
  assign push       = mem_req && mem_gnt;
  assign fifo_empty = (fifo_cnt == '0);
  assign do_pop     = pop && !fifo_empty;
  assign head       = q[rd_ptr];

  always_ff @(posedge clk) begin
    if (push) q[wr_ptr] <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb       <= '0;
      wr_ptr   <= '0;
      rd_ptr   <= '0;
      fifo_cnt <= '0;
    end else begin
      if (!line_active)  fb <= '0;
      else if (push)     fb <= fb + 1'b1;
      if (push)   wr_ptr <= wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      case ({push, do_pop})
        2'b10:   fifo_cnt <= fifo_cnt + 1'b1;
        2'b01:   fifo_cnt <= fifo_cnt - 1'b1;
        default: fifo_cnt <= fifo_cnt;
      endcase
    end
  end
endmodule

// File: rtl/lgr_pixel.sv
module lgr_pixel
  import lgr_pkg::*;
#(
  parameter int DIM_W = 7
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         line_active,
  input  logic                         fifo_empty,
  input  logic [7:0]                   head,
  input  logic [1:0]                   cfg_mode,
  input  logic [1:0]                   cfg_bus,
  input  logic [DIM_W-1:0]             cfg_width,
  input  logic [PAL_ENTRIES*PAL_W-1:0] cfg_palette,
  input  logic [PAL_W-1:0]             frc_phase,
  output logic                         take,
  output logic                         pop,
  output logic                         line_done,
  output logic [7:0]                   lcd_data,
  output logic                         lcd_shift
);
  logic [DIM_W-1:0] x;
  logic [2:0]       sub;
  logic [3:0]       gcnt, lanes, pos, code;
  logic [7:0]       acc, next_acc;
  logic [PAL_W-1:0] lvl;
  logic             last_px, last_sub, group_end, dot;

  assign take      = line_active && !fifo_empty;
  assign last_px   = (x == DIM_W'(cfg_width - 1'b1));
  assign last_sub  = (sub == sub_last(cfg_mode));
  assign line_done = take && last_px;
  assign pop       = take && (last_px || last_sub);

  assign code      = pix_code(head, cfg_mode, sub);
  assign lvl       = cfg_palette[int'(code)*PAL_W +: PAL_W];
  assign dot       = frc_on(lvl, frc_phase);

  assign lanes     = bus_lanes(cfg_bus);
  assign pos       = lanes - 4'd1 - gcnt;
  assign next_acc  = acc | (8'(dot) << pos);
  assign group_end = (gcnt == lanes - 4'd1) || last_px;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      x         <= '0;
      sub       <= '0;
      gcnt      <= '0;
      acc       <= '0;
      lcd_data  <= '0;
      lcd_shift <= 1'b0;
    end else begin
      lcd_shift <= 1'b0;
      if (take) begin
        if (last_px) begin
          x   <= '0;
          sub <= '0;
        end else begin
          x   <= x + 1'b1;
          sub <= last_sub ? 3'd0 : sub + 3'd1;
        end
        if (group_end) begin
          lcd_data  <= next_acc;
          lcd_shift <= 1'b1;
          acc       <= '0;
          gcnt      <= '0;
        end else begin
          acc  <= next_acc;
          gcnt <= gcnt + 4'd1;
        end
      end
    end
  end
endmodule

// File: rtl/lcd_gray_refresh.sv
module lcd_gray_refresh
  import lgr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W = 7,
  parameter int STRIDE_W = 8,
  parameter int FIFO_DEPTH = 4,
  parameter int VBL_CYCLES = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [1:0]                   cfg_mode,
  input  logic [1:0]                   cfg_bus,
  input  logic [DIM_W-1:0]             cfg_width,
  input  logic [DIM_W-1:0]             cfg_height,
  input  logic [ADDR_W-1:0]            cfg_base,
  input  logic [STRIDE_W-1:0]          cfg_stride,
  input  logic [PAL_ENTRIES*PAL_W-1:0] cfg_palette,
  output logic                         mem_req,
  output logic [ADDR_W-1:0]            mem_addr,
  input  logic                         mem_gnt,
  input  logic [7:0]                   mem_rdata,
  output logic [7:0]                   lcd_data,
  output logic                         lcd_shift,
  output logic                         lcd_line,
  output logic                         lcd_frame,
  output logic                         lcd_alt,
  output logic                         buf_irq
);
  localparam int NB_W  = DIM_W + 1;
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1);

  logic              line_active, line_done, vbl_enter, take, pop, fifo_empty;
  logic [ADDR_W-1:0] line_base;
  logic [PAL_W-1:0]  frc_phase;
  logic [7:0]        head;
  logic [CNT_W-1:0]  fifo_cnt;
  logic [NB_W-1:0]   nbytes;

  assign nbytes = NB_W'(line_bytes(32'(cfg_width), 32'(pix_bits(cfg_mode))));

  lgr_seq #(.DIM_W(DIM_W), .ADDR_W(ADDR_W), .STRIDE_W(STRIDE_W), .VBL_CYCLES(VBL_CYCLES)) u_seq (
    .clk, .rst_n, .cfg_height, .cfg_base, .cfg_stride, .line_done,
    .line_active, .line_base, .frc_phase, .vbl_enter,
    .lcd_line, .lcd_frame, .lcd_alt, .buf_irq
  );

  lgr_fetch #(.ADDR_W(ADDR_W), .NB_W(NB_W), .DEPTH(FIFO_DEPTH)) u_fetch (
    .clk, .rst_n, .line_active, .line_base, .nbytes, .mem_gnt, .mem_rdata, .pop,
    .mem_req, .mem_addr, .head, .fifo_empty, .fifo_cnt
  );

  lgr_pixel #(.DIM_W(DIM_W)) u_pixel (
    .clk, .rst_n, .line_active, .fifo_empty, .head, .cfg_mode, .cfg_bus, .cfg_width,
    .cfg_palette, .frc_phase, .take, .pop, .line_done, .lcd_data, .lcd_shift
  );
endmodule

// File: rtl/lgr_chk.sv
module lgr_chk #(
  parameter int ADDR_W = 16,
  parameter int DEPTH = 4,
  parameter int CNT_W = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mem_req,
  input logic              mem_gnt,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              line_active,
  input logic [CNT_W-1:0]  fifo_cnt,
  input logic              vbl_enter,
  input logic              buf_irq,
  input logic              lcd_alt,
  input logic              lcd_line,
  input logic              lcd_frame,
  input logic              lcd_shift
);
  assert_req_in_line_R7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> line_active);
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_addr)));
  assert_no_overflow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_cnt <= CNT_W'(DEPTH));
  assert_irq_follows_vbl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    vbl_enter |=> buf_irq);
  assert_irq_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_irq |=> !buf_irq);
  assert_alt_flip_R8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_irq |-> (lcd_alt != $past(lcd_alt)));
  assert_irq_with_line_R8: assert property (@(posedge clk) disable iff (!rst_n)
    buf_irq |-> lcd_line);
  assert_frame_on_line_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_frame |-> lcd_line);
  assert_line_no_shift_R5: assert property (@(posedge clk) disable iff (!rst_n)
    lcd_line |-> !lcd_shift);
endmodule

bind lcd_gray_refresh lgr_chk #(.ADDR_W(ADDR_W), .DEPTH(FIFO_DEPTH), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_gnt(mem_gnt), .mem_addr(mem_addr),
  .line_active(line_active), .fifo_cnt(fifo_cnt), .vbl_enter(vbl_enter),
  .buf_irq(buf_irq), .lcd_alt(lcd_alt), .lcd_line(lcd_line), .lcd_frame(lcd_frame),
  .lcd_shift(lcd_shift)
);

// File: tb/lcd_gray_refresh_tb.sv
module lcd_gray_refresh_tb;
  localparam int ADDR_W = 16;
  localparam int DIM_W = 7;
  localparam int STRIDE_W = 8;
  localparam int VBL_CYCLES = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] cfg_mode = '0, cfg_bus = '0;
  logic [DIM_W-1:0] cfg_width = 7'd1, cfg_height = 7'd1;
  logic [ADDR_W-1:0] cfg_base = '0;
  logic [STRIDE_W-1:0] cfg_stride = '0;
  logic [79:0] cfg_palette = '0;
  logic mem_req, mem_gnt = 1'b0, lcd_shift, lcd_line, lcd_frame, lcd_alt, buf_irq;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_rdata, lcd_data;

  always #5 clk = ~clk;

  lcd_gray_refresh #(.ADDR_W(ADDR_W), .DIM_W(DIM_W), .STRIDE_W(STRIDE_W),
                     .VBL_CYCLES(VBL_CYCLES)) u_dut (
    .clk, .rst_n, .cfg_mode, .cfg_bus, .cfg_width, .cfg_height, .cfg_base, .cfg_stride,
    .cfg_palette, .mem_req, .mem_addr, .mem_gnt, .mem_rdata, .lcd_data, .lcd_shift,
    .lcd_line, .lcd_frame, .lcd_alt, .buf_irq
  );

  logic [7:0] mem_img [0:4095];
  assign mem_rdata = mem_img[mem_addr[11:0]];

  bit gnt_random = 0;
  always @(negedge clk) mem_gnt <= gnt_random ? ($urandom_range(0, 2) != 0) : 1'b1;

  int checks = 0, fails = 0;
  int pal_v [16];
  int t_mode, t_bus, t_w, t_h, t_base, t_stride;
  string cur_tag = "";
  logic [7:0] exp_q [$];
  int lines_seen, lines_in_frame, frames_seen, irqs_seen;
  bit running = 0, prev_irq = 0, done = 0;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  // scoreboard driver: computes every expected panel word from the requirements
  task automatic build_expect(input int frames);
    int bpp, lanes, word, bitpos, addr, code, mask;
    bpp   = (t_mode == 0) ? 1 : (t_mode == 1) ? 2 : 4;
    lanes = (t_bus == 0) ? 1 : (t_bus == 1) ? 4 : 8;
    mask  = (1 << bpp) - 1;
    for (int f = 0; f < frames; f++) begin
      for (int y = 0; y < t_h; y++) begin
        word = 0;
        for (int x = 0; x < t_w; x++) begin
          bitpos = x * bpp;
          addr = (t_base + y * t_stride + bitpos / 8) & 'hfff;
          code = (int'(mem_img[addr]) >> (8 - bpp - (bitpos % 8))) & mask;
          if (pal_v[code] > (f % 32)) word = word | (1 << (lanes - 1 - (x % lanes)));
          if ((x % lanes) == lanes - 1 || x == t_w - 1) begin
            exp_q.push_back(8'(word));
            word = 0;
          end
        end
      end
    end
  endtask

  // monitor: compares produced words and frame timing against the scoreboard
  always @(negedge clk) begin
    if (rst_n && running) begin
      if (lcd_shift) begin
        if (exp_q.size() == 0) check(0, cur_tag, "R5 extra word", int'(lcd_data), -1);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          check(lcd_data == e, cur_tag, "R2/R3/R4/R6 data word", int'(lcd_data), int'(e));
        end
      end
      if (lcd_line) begin
        check(!lcd_shift, cur_tag, "R5 line pulse with strobe", int'(lcd_shift), 0);
        if (lcd_frame) begin
          frames_seen++;
          check(lines_in_frame == 0, cur_tag, "R9 frame marker line", lines_in_frame, 0);
        end
        lines_seen++;
        lines_in_frame++;
      end else begin
        check(!lcd_frame, cur_tag, "R9 frame marker alone", int'(lcd_frame), 0);
      end
      if (buf_irq) begin
        irqs_seen++;
        check(!prev_irq, cur_tag, "R8 irq width", int'(prev_irq), 0);
        check(lcd_line, cur_tag, "R8 irq with last line", int'(lcd_line), 1);
        check(!mem_req, cur_tag, "R7 request in blanking", int'(mem_req), 0);
        check(lines_in_frame == t_h, cur_tag, "R5 lines per frame", lines_in_frame, t_h);
        lines_in_frame = 0;
      end
      prev_irq = buf_irq;
    end
  end

  task automatic run_test(input string tag, input int mode, input int bus, input int w,
                          input int h, input int base, input int stride, input int frames,
                          input bit rnd, input int seed);
    int wait_cyc;
    @(negedge clk);
    rst_n = 0; running = 0;
    cur_tag = tag;
    t_mode = mode; t_bus = bus; t_w = w; t_h = h; t_base = base; t_stride = stride;
    for (int i = 0; i < 16; i++) pal_v[i] = (i * 11 + seed) % 32;
    pal_v[0] = 0; pal_v[15] = 31;
    for (int i = 0; i < 16; i++) cfg_palette[i*5 +: 5] = 5'(pal_v[i]);
    cfg_mode = 2'(mode); cfg_bus = 2'(bus); cfg_width = 7'(w); cfg_height = 7'(h);
    cfg_base = 16'(base); cfg_stride = 8'(stride); gnt_random = rnd;
    exp_q.delete();
    lines_seen = 0; lines_in_frame = 0; frames_seen = 0; irqs_seen = 0; prev_irq = 0;
    build_expect(frames);
    repeat (3) @(negedge clk);
    check(!mem_req && !lcd_shift && !lcd_line && !lcd_frame && !lcd_alt && !buf_irq
          && lcd_data == 0, tag, "R1 outputs in reset", int'(mem_req), 0);
    rst_n = 1; running = 1;
    wait_cyc = 0;
    while (!mem_req && wait_cyc < 40) begin
      @(negedge clk);
      wait_cyc++;
    end
    check(wait_cyc >= VBL_CYCLES, tag, "R1 initial blanking length", wait_cyc, VBL_CYCLES);
    while (irqs_seen < frames) @(negedge clk);
    @(negedge clk);
    check(exp_q.size() == 0, tag, "R5 missing words", exp_q.size(), 0);
    check(lines_seen == h * frames, tag, "R5 total lines", lines_seen, h * frames);
    check(frames_seen == frames, tag, "R9 frame markers", frames_seen, frames);
    check(int'(lcd_alt) == frames % 2, tag, "R8 alternation", int'(lcd_alt), frames % 2);
    running = 0;
    rst_n = 0;
  endtask

  initial begin
    for (int i = 0; i < 4096; i++) mem_img[i] = 8'((i * 37) ^ (i >> 3) ^ 'h5a);
    run_test("R2 R3 R4 gray16 bus8", 2, 2, 20, 6, 'h100, 10, 3, 0, 3);
    run_test("R2 R4 bw bus1", 0, 0, 13, 4, 'h200, 2, 2, 1, 17);
    run_test("R2 R4 gray4 bus4 partial", 1, 1, 10, 5, 'h300, 3, 2, 1, 9);
    run_test("R6 virtual pan", 1, 2, 12, 5, 'h455, 20, 2, 1, 5);
    run_test("R6 R7 wrap stride", 2, 1, 9, 3, 'hffe, 200, 2, 1, 21);
    run_test("R3 frc sweep", 0, 2, 8, 2, 'h10, 1, 34, 0, 17);
    run_test("R5 max size", 2, 2, 100, 100, 0, 50, 1, 0, 12);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, actual 0 expected 1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule